// File: doc/BRIEF.md
# Adaptive Insertion Replacement Controller

This block keeps the replacement order for every set of a set-associative cache and decides where a newly filled line enters that order. Each set holds a full recency stack, a permutation of its way numbers running from most recently used (position 0) to least recently used (position WAYS-1). A hit promotes the touched way to the top. A miss names the way at the bottom as the victim, and the incoming line takes that way. The line is then either lifted to the top of the stack (conventional insertion) or left at the bottom, where it is evicted next unless it is touched first.

The insertion choice adapts at run time. Sets whose index has low bits equal to 0 always insert at the top. Sets whose low bits equal 1 always use a bimodal rule: they insert at the top only when a free-running pseudo-random value falls under a small throttle, and at the bottom otherwise. Misses in these two groups of sample sets move one saturating selector counter in opposite directions. Every other set follows whichever rule the counter's top bit currently favours. The cache pipeline presents one lookup result per cycle: the set index, hit or miss, and the hit way. One cycle later it receives the victim and the new stack of that set. Tag and data storage lie outside this block.

Top module: `dip_replacement`

## Requirements
- R1: After reset every set's stack holds way p at position p, so the first victim of an untouched set is way WAYS-1. The selector counter starts at 2^(PSEL_W-1)-1, so followBip is 0. respValid, victimValid and insertMru are 0.
- R2: On a hit to way w at position k, the next stateOut places w at position 0. The ways formerly at positions 0..k-1 move down by one position, and positions below k are unchanged. stateOut packs position p into bits [p*WAY_W +: WAY_W].
- R3: On a miss, victimValid is 1 in the cycle after the request and victimWay is the way that held position WAYS-1 before the request. victimValid is 0 after a hit or an idle cycle.
- R4: A miss to a set whose index bits [DUEL_W-1:0] equal 0 always inserts at the top: insertMru is 1, the victim moves to position 0 and the other ways move down by one.
- R5: A miss to a set whose index bits [DUEL_W-1:0] equal 1 uses the bimodal rule. When insertMru is 0 the stack is unchanged. insertMru is 1 only when the low THR_W bits of the free-running generator are all zero, which is roughly one miss in 2^THR_W.
- R6: The selector counter rises by one on a miss in an index-0 sample set and falls by one on a miss in an index-1 sample set. It saturates at 0 and at 2^PSEL_W-1. followBip shows its top bit.
- R7: A miss to any other set uses top insertion when the counter's top bit is 0 and the bimodal rule when it is 1. The top bit is read before that same request's counter update.
- R8: Hits never change the selector counter.
- R9: In a cycle without a request no stack and no counter changes, and respValid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A lookup result is presented this cycle |
| reqSet | input | SET_W | Set index of the lookup |
| reqHit | input | 1 | 1 for hit, 0 for miss |
| reqWay | input | WAY_W | Way that hit (ignored on a miss) |
| victimValid | output | 1 | The previous request was a miss |
| victimWay | output | WAY_W | Way to refill for that miss |
| respValid | output | 1 | The previous cycle carried a request |
| stateOut | output | WAYS*WAY_W | Updated recency stack of that set, position 0 in the low bits |
| insertMru | output | 1 | The previous miss placed its line at the top |
| followBip | output | 1 | Current policy of the follower sets (1 = bimodal) |

## Verification
The case that interacts is a miss in a sample set that moves the selector counter across its midpoint, followed in the very next cycle by a miss in a follower set. The first miss changes the policy, and the second must already use the new one. The bench provokes this by driving the two misses back to back from both directions of the crossing. A reference model updates its counter only after it has chosen the insertion for the current request, and so judges the follower's insertMru and stack. A sample-set miss whose own insertion and counter change happen in the same cycle is covered by the same comparison.

// File: rtl/dip_pkg.sv
package dip_pkg;
  // strobes handed from the policy control to the recency datapath
  typedef struct packed {
    logic touch;      // a request is applied this cycle
    logic hit;        // request is a hit
    logic insertMru;  // on a miss, place the filled way at the top
  } strobe_t;
endpackage

// File: rtl/dip_policy_ctrl.sv
module dip_policy_ctrl
  import dip_pkg::*;
#(
  parameter int SET_W  = 6,
  parameter int DUEL_W = 5,
  parameter int PSEL_W = 10,
  parameter int THR_W  = 5,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [SET_W-1:0] reqSet,
  input  logic             reqHit,
  output strobe_t          strb,
  output logic             followBip
);
  localparam logic [PSEL_W-1:0] PSEL_MAX  = '1;
  localparam logic [PSEL_W-1:0] PSEL_ZERO = '0;
  localparam logic [PSEL_W-1:0] PSEL_INIT = {1'b0, {(PSEL_W-1){1'b1}}};
  localparam logic [LFSR_W-1:0] LFSR_SEED = {{(LFSR_W-1){1'b0}}, 1'b1};

  logic [PSEL_W-1:0] psel;
  logic [LFSR_W-1:0] lfsr;
  logic [DUEL_W-1:0] slot;
  logic isMruLeader, isBipLeader, useBip, coinMru, missNow;

  assign slot        = reqSet[DUEL_W-1:0];
  assign isMruLeader = (slot == DUEL_W'(0));
  assign isBipLeader = (slot == DUEL_W'(1));
  assign missNow     = reqValid & ~reqHit;
  assign coinMru     = (lfsr[THR_W-1:0] == '0);
  assign useBip      = isBipLeader | (~isMruLeader & psel[PSEL_W-1]);

  always_comb begin
    strb.touch     = reqValid;
    strb.hit       = reqHit;
    strb.insertMru = ~useBip | coinMru;
  end

  assign followBip = psel[PSEL_W-1];

  // free-running Galois shift register
  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_SEED;
    else     lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // saturating selector counter
  always_ff @(posedge clk) begin
    if (rst) begin
      psel <= PSEL_INIT;
    end else if (missNow) begin
      if (isMruLeader && psel != PSEL_MAX)       psel <= psel + 1'b1;
      else if (isBipLeader && psel != PSEL_ZERO) psel <= psel - 1'b1;
    end
  end
endmodule

// File: rtl/dip_recency_dp.sv
module dip_recency_dp
  import dip_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int WAY_W = 2,
  parameter int SET_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [SET_W-1:0]      reqSet,
  input  logic [WAY_W-1:0]      reqWay,
  output logic                  respValid,
  output logic [WAYS*WAY_W-1:0] stateOut,
  output logic                  victimValid,
  output logic [WAY_W-1:0]      victimWay,
  output logic                  insertMru
);
  typedef logic [WAYS-1:0][WAY_W-1:0] stack_t;

  stack_t stackMem [SETS];
  stack_t cur, nxt;
  logic [WAY_W-1:0] hitPos;
  logic [WAY_W-1:0] bottomWay;

  assign cur       = stackMem[reqSet];
  assign bottomWay = cur[WAYS-1];

  always_comb begin
    hitPos = '0;
    for (int p = 0; p < WAYS; p++)
      if (cur[p] == reqWay) hitPos = WAY_W'(p);
  end

  always_comb begin
    nxt = cur;
    if (strb.hit) begin
      nxt[0] = reqWay;
      for (int p = 1; p < WAYS; p++)
        if (p <= int'(hitPos)) nxt[p] = cur[p-1];
    end else if (strb.insertMru) begin
      nxt[0] = bottomWay;
      for (int p = 1; p < WAYS; p++) nxt[p] = cur[p-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int p = 0; p < WAYS; p++)
          stackMem[s][p] <= WAY_W'(p);
    end else if (strb.touch) begin
      stackMem[reqSet] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid   <= 1'b0;
      victimValid <= 1'b0;
      insertMru   <= 1'b0;
      victimWay   <= '0;
      stateOut    <= '0;
    end else begin
      respValid   <= strb.touch;
      victimValid <= strb.touch & ~strb.hit;
      insertMru   <= strb.touch & ~strb.hit & strb.insertMru;
      if (strb.touch) begin
        stateOut <= nxt;
        if (!strb.hit) victimWay <= bottomWay;
      end
    end
  end
endmodule

// File: rtl/dip_replacement.sv
module dip_replacement
  import dip_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int PSEL_W = 10,
  parameter int DUEL_W = 5,
  parameter int THR_W  = 5,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic [SET_W-1:0]      reqSet,
  input  logic                  reqHit,
  input  logic [WAY_W-1:0]      reqWay,
  output logic                  victimValid,
  output logic [WAY_W-1:0]      victimWay,
  output logic                  respValid,
  output logic [WAYS*WAY_W-1:0] stateOut,
  output logic                  insertMru,
  output logic                  followBip
);
  strobe_t strb;

  dip_policy_ctrl #(
    .SET_W(SET_W), .DUEL_W(DUEL_W), .PSEL_W(PSEL_W),
    .THR_W(THR_W), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSet(reqSet),
    .reqHit(reqHit), .strb(strb), .followBip(followBip)
  );

  dip_recency_dp #(
    .WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqSet(reqSet), .reqWay(reqWay),
    .respValid(respValid), .stateOut(stateOut), .victimValid(victimValid),
    .victimWay(victimWay), .insertMru(insertMru)
  );
endmodule

// File: rtl/dip_replacement_chk.sv
module dip_replacement_chk #(
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int SET_W  = 6,
  parameter int DUEL_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reqValid,
  input logic [SET_W-1:0]      reqSet,
  input logic                  reqHit,
  input logic                  victimValid,
  input logic                  respValid,
  input logic [WAYS*WAY_W-1:0] stateOut,
  input logic                  insertMru,
  input logic                  followBip
);
  logic permOk;
  always_comb begin
    permOk = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      int seen;
      seen = 0;
      for (int p = 0; p < WAYS; p++)
        if (stateOut[p*WAY_W +: WAY_W] == WAY_W'(w)) seen++;
      if (seen != 1) permOk = 1'b0;
    end
  end

  AST_STACK_PERM:   assert property (@(posedge clk) disable iff (rst) respValid |-> permOk);                                   // R2
  AST_MISS_VICTIM:  assert property (@(posedge clk) disable iff (rst) (reqValid && !reqHit) |=> victimValid);                 // R3
  AST_HIT_NOVICT:   assert property (@(posedge clk) disable iff (rst) !(reqValid && !reqHit) |=> !victimValid);               // R3
  AST_LEADER_MRU:   assert property (@(posedge clk) disable iff (rst)
                      (reqValid && !reqHit && reqSet[DUEL_W-1:0] == '0) |=> insertMru);                                       // R4
  AST_HIT_KEEPSEL:  assert property (@(posedge clk) disable iff (rst) (reqValid && reqHit) |=> $stable(followBip));           // R8
  AST_IDLE_KEEPSEL: assert property (@(posedge clk) disable iff (rst) !reqValid |=> ($stable(followBip) && !respValid));      // R9
  AST_RESP_FOLLOW:  assert property (@(posedge clk) disable iff (rst) reqValid |=> respValid);                                 // R9
endmodule

bind dip_replacement dip_replacement_chk #(
  .WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W), .DUEL_W(DUEL_W)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqSet(reqSet), .reqHit(reqHit),
  .victimValid(victimValid), .respValid(respValid), .stateOut(stateOut),
  .insertMru(insertMru), .followBip(followBip)
);

// File: tb/sim_dip_replacement.sv
module sim_dip_replacement;
  localparam int NW = 4;
  localparam int NS = 64;
  localparam int PMAX = 1023;
  localparam int PMID = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [5:0] reqSet = '0;
  logic reqHit = 1'b0;
  logic [1:0] reqWay = '0;
  logic victimValid, respValid, insertMru, followBip;
  logic [1:0] victimWay;
  logic [7:0] stateOut;

  always #2 clk = ~clk;

  dip_replacement u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSet(reqSet), .reqHit(reqHit),
    .reqWay(reqWay), .victimValid(victimValid), .victimWay(victimWay),
    .respValid(respValid), .stateOut(stateOut), .insertMru(insertMru),
    .followBip(followBip)
  );

  typedef struct { int set; bit hit; int way; } item_t;
  item_t pending[$];

  int mdl [NS][NW];
  int psel;
  int nChecks = 0;
  int nErr = 0;
  int bipMiss = 0;
  int bipTop = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NW; p++) mdl[s][p] = p;
    psel = PMID - 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    pending.delete();
    rst = 1'b0;
  endtask

  // driver: one request per call, back to back unless idle() follows
  task automatic req(input int set, input bit hit, input int way);
    item_t it;
    @(negedge clk);
    reqValid = 1'b1; reqSet = 6'(set); reqHit = hit; reqWay = 2'(way);
    it.set = set; it.hit = hit; it.way = way;
    pending.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) continue;
      if (pending.size() == 0) begin
        check(respValid == 1'b0, "R9 respValid idle", respValid, 0);
        check(victimValid == 1'b0, "R3 victimValid idle", victimValid, 0);
      end else begin
        item_t it;
        int slot, expState, pos;
        bit bip, top;
        string tag;
        it = pending.pop_front();
        slot = it.set % 32;
        check(respValid == 1'b1, "R9 respValid after request", respValid, 1);
        if (it.hit) begin
          pos = 0;
          for (int p = 0; p < NW; p++) if (mdl[it.set][p] == it.way) pos = p;
          for (int p = pos; p > 0; p--) mdl[it.set][p] = mdl[it.set][p-1];
          mdl[it.set][0] = it.way;
          check(victimValid == 1'b0, "R3 no victim on hit", victimValid, 0);
          tag = "R2 stack after hit";
        end else begin
          int vic;
          vic = mdl[it.set][NW-1];
          check(victimValid == 1'b1, "R3 victimValid on miss", victimValid, 1);
          check(int'(victimWay) == vic, "R3 victim way", victimWay, vic);
          bip = (slot == 1) || (slot != 0 && psel >= PMID);
          if (!bip) begin
            top = 1'b1;
            if (slot == 0) check(insertMru == 1'b1, "R4 sample set top insertion", insertMru, 1);
            else check(insertMru == 1'b1, "R7 follower top insertion", insertMru, 1);
          end else begin
            top = insertMru;
            if (slot == 1) begin bipMiss++; if (top) bipTop++; end
          end
          if (top) begin
            for (int p = NW - 1; p > 0; p--) mdl[it.set][p] = mdl[it.set][p-1];
            mdl[it.set][0] = vic;
          end
          if (slot == 0 && psel < PMAX) psel++;
          else if (slot == 1 && psel > 0) psel--;
          tag = (slot == 0) ? "R4 stack after miss" : (slot == 1) ? "R5 stack after miss" : "R7 stack after miss";
        end
        expState = 0;
        for (int p = 0; p < NW; p++) expState |= mdl[it.set][p] << (2 * p);
        check(int'(stateOut) == expState, tag, stateOut, expState);
        if (it.hit) check(followBip == (psel >= PMID), "R8 selector after hit", followBip, psel >= PMID);
        else        check(followBip == (psel >= PMID), "R6 selector after miss", followBip, psel >= PMID);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    #1;
    check(respValid == 1'b0, "R1 respValid after reset", respValid, 0);
    check(victimValid == 1'b0, "R1 victimValid after reset", victimValid, 0);
    check(insertMru == 1'b0, "R1 insertMru after reset", insertMru, 0);
    check(followBip == 1'b0, "R1 followBip after reset", followBip, 0);
    // R1: untouched follower set evicts way 3 first, top insertion while followBip=0
    req(5, 0, 0);
    idle(1);
    // R2: hits at various depths, back to back
    req(2, 1, 2); req(2, 1, 0); req(2, 1, 3); req(2, 1, 3); req(2, 1, 1);
    idle(2);
    // R6/R7: sample miss crosses midpoint, follower miss immediately after
    req(32, 0, 0); req(3, 0, 0); req(3, 0, 0);
    idle(1);
    // crossing back down, follower right behind
    req(1, 0, 0); req(4, 0, 0); req(4, 1, 1);
    idle(1);
    // R8: hits in sample sets leave the selector alone
    req(0, 1, 2); req(33, 1, 0); req(32, 1, 3);
    idle(1);
    // R6: drive selector to the top and hold it saturated
    for (int i = 0; i < 1100; i++) req((i % 2) ? 0 : 32, 0, 0);
    idle(1);
    req(33, 0, 0); req(6, 0, 0);
    idle(1);
    // R6/R5: fresh state, drive selector down to zero and keep going
    doReset();
    for (int i = 0; i < 600; i++) req((i % 2) ? 1 : 33, 0, 0);
    idle(2);
    req(0, 0, 0); req(7, 0, 0);
    idle(1);
    // R5: rate of top insertions in bimodal sample sets
    for (int i = 0; i < 3; i++) idle(1);
    check(bipTop >= 1 && bipTop <= 60, "R5 bimodal top insertion rate", bipTop, bipMiss / 32);
    check(bipTop < bipMiss / 4, "R5 bimodal mostly bottom insertion", bipTop, bipMiss / 32);
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule